// File: doc/BRIEF.md
# Return Status Restore and Privilege Check

This block performs the register-transfer step of a return from a subprogram or exception handler. It receives the decoded fields of an instruction and the two words of the source register pair. The first word carries the return address. The second word carries the saved status. The block also receives the current status register. When the instruction is the return form of the double-word move, the block builds the new program counter and the new status word. It also decides whether the return raises a privilege-error trap.

The return form uses the same opcode as the double-word move. It is picked out when the destination field names the program counter. Two source encodings are reserved: the program-counter index and the status-register index. Either one raises an illegal-operand pulse and leaves all architectural state unchanged. All results are registered. A done pulse follows the strobe by one cycle.

When a trap is raised, the restored values are still presented on the outputs, including any supervisor or lock flag that was set illegally. This lets exception handling save them. The memory-to-register stack refill is handled elsewhere.

Top module: `ret_restore_unit`

## Requirements
- R1: A strobe counts as a return only when `opcode_i` equals parameter `MOVD_OPC` (default 6'h26) and `dst_sel_i` equals `PC_IDX` (default 0). Any other strobe gives no done pulse and leaves `pc_o` and `sr_o` unchanged.
- R2: On a legal return, `pc_o` becomes bits 31..1 of `pc_word_i` with bit 0 set to zero.
- R3: On a legal return, `sr_o` takes bits 31..21 and 17..0 from `sr_word_i`. Bits 20..19 (instruction length code) become zero. Bit 18 (supervisor flag) comes from bit 0 of `pc_word_i`.
- R4: `priv_trap_o` pulses with done when the old supervisor flag (`cur_sr_i[18]`) is 0 and the new one is 1.
- R5: `priv_trap_o` also pulses when the new supervisor flag is 0, the old lock flag (`cur_sr_i[15]`) is 0, and the new lock flag (`sr_word_i[15]`) is 1. No other flag combination traps.
- R6: When a trap is raised, `pc_o` and `sr_o` still take the restored values of R2 and R3, including any illegally set flag.
- R7: A return whose `src_sel_i` equals `PC_IDX` or `SR_IDX` (default 1) pulses `illegal_o`. It leaves `pc_o` and `sr_o` unchanged and raises no trap.
- R8: `done_o` pulses exactly one cycle after every return-form strobe, whether the source is legal or reserved.
- R9: An active-low asynchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| opcode_i | input | 6 | Basic opcode field |
| dst_sel_i | input | 4 | Destination register field |
| src_sel_i | input | 4 | Source register field |
| pc_word_i | input | 32 | First source word (return address, bit 0 = supervisor) |
| sr_word_i | input | 32 | Second source word (saved status) |
| cur_sr_i | input | 32 | Current status register |
| pc_o | output | 32 | Restored program counter |
| sr_o | output | 32 | Restored status word |
| priv_trap_o | output | 1 | Privilege-error trap request pulse |
| illegal_o | output | 1 | Reserved source encoding pulse |
| done_o | output | 1 | Return completion pulse |

## Verification
The bound checker tests the following on every cycle:
- the done pulse timing;
- the forced-zero program-counter bit;
- the cleared length code;
- the supervisor flag taken from the address word;
- both trap conditions against the inputs of the previous cycle;
- the state held across a reserved encoding.

Only the bench scenarios can show certain other behaviour:
- decode rejection of near-miss opcodes and destinations, where state stays unchanged over many cycles;
- the full old/new flag sweep, with trap-time values preserved;
- reset arriving after state has been loaded.

// File: rtl/ret_pkg.sv
package ret_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned S_BIT   = 18;
  localparam int unsigned ILC_LO  = 19;
  localparam int unsigned ILC_HI  = 20;
  localparam int unsigned L_BIT   = 15;
  localparam int unsigned ILC_W   = ILC_HI - ILC_LO + 1;

  typedef struct packed {
    logic sup;
    logic lock;
  } priv_flags_t;
endpackage

// File: rtl/ret_decode.sv
module ret_decode #(
  parameter int unsigned OPC_W    = 6,
  parameter int unsigned REG_W    = 4,
  parameter logic [OPC_W-1:0] MOVD_OPC = 6'h26,
  parameter int unsigned PC_IDX   = 0,
  parameter int unsigned SR_IDX   = 1
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [REG_W-1:0] dst_sel_i,
  input  logic [REG_W-1:0] src_sel_i,
  output logic             ret_any_o,
  output logic             ret_ok_o,
  output logic             ret_bad_o
);
  localparam logic [REG_W-1:0] PC_SEL = REG_W'(PC_IDX);
  localparam logic [REG_W-1:0] SR_SEL = REG_W'(SR_IDX);

  logic src_rsvd;

  always_comb begin
    ret_any_o = valid_i && (opcode_i == MOVD_OPC) && (dst_sel_i == PC_SEL);
    src_rsvd  = (src_sel_i == PC_SEL) || (src_sel_i == SR_SEL);
    ret_bad_o = ret_any_o && src_rsvd;
    ret_ok_o  = ret_any_o && !src_rsvd;
  end
endmodule

// File: rtl/ret_status_build.sv
module ret_status_build
  import ret_pkg::*;
(
  input  logic [XLEN-1:0] pc_word_i,
  input  logic [XLEN-1:0] sr_word_i,
  output logic [XLEN-1:0] pc_new_o,
  output logic [XLEN-1:0] sr_new_o,
  output priv_flags_t     new_flags_o
);
  always_comb begin
    pc_new_o                = {pc_word_i[XLEN-1:1], 1'b0};
    sr_new_o                = sr_word_i;
    sr_new_o[ILC_HI:ILC_LO] = '0;
    sr_new_o[S_BIT]         = pc_word_i[0];
    new_flags_o.sup         = pc_word_i[0];
    new_flags_o.lock        = sr_word_i[L_BIT];
  end
endmodule

// File: rtl/ret_priv_check.sv
module ret_priv_check
  import ret_pkg::*;
(
  input  priv_flags_t old_flags_i,
  input  priv_flags_t new_flags_i,
  output logic        trap_o
);
  logic sup_raise, lock_raise;

  always_comb begin
    sup_raise  = !old_flags_i.sup && new_flags_i.sup;
    // lock may only be raised while staying in or entering supervisor
    lock_raise = !new_flags_i.sup && !old_flags_i.lock && new_flags_i.lock;
    trap_o     = sup_raise || lock_raise;
  end
endmodule

// File: rtl/ret_restore_unit.sv
module ret_restore_unit
  import ret_pkg::*;
#(
  parameter int unsigned OPC_W    = 6,
  parameter int unsigned REG_W    = 4,
  parameter logic [OPC_W-1:0] MOVD_OPC = 6'h26,
  parameter int unsigned PC_IDX   = 0,
  parameter int unsigned SR_IDX   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [REG_W-1:0] dst_sel_i,
  input  logic [REG_W-1:0] src_sel_i,
  input  logic [XLEN-1:0]  pc_word_i,
  input  logic [XLEN-1:0]  sr_word_i,
  input  logic [XLEN-1:0]  cur_sr_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sr_o,
  output logic             priv_trap_o,
  output logic             illegal_o,
  output logic             done_o
);
  logic            ret_any, ret_ok, ret_bad, trap;
  logic [XLEN-1:0] pc_new, sr_new;
  priv_flags_t     new_flags, old_flags;

  assign old_flags.sup  = cur_sr_i[S_BIT];
  assign old_flags.lock = cur_sr_i[L_BIT];

  ret_decode #(
    .OPC_W(OPC_W), .REG_W(REG_W), .MOVD_OPC(MOVD_OPC),
    .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)
  ) u_dec (
    .valid_i  (valid_i),
    .opcode_i (opcode_i),
    .dst_sel_i(dst_sel_i),
    .src_sel_i(src_sel_i),
    .ret_any_o(ret_any),
    .ret_ok_o (ret_ok),
    .ret_bad_o(ret_bad)
  );

  ret_status_build u_build (
    .pc_word_i  (pc_word_i),
    .sr_word_i  (sr_word_i),
    .pc_new_o   (pc_new),
    .sr_new_o   (sr_new),
    .new_flags_o(new_flags)
  );

  ret_priv_check u_priv (
    .old_flags_i(old_flags),
    .new_flags_i(new_flags),
    .trap_o     (trap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o        <= '0;
      sr_o        <= '0;
      priv_trap_o <= 1'b0;
      illegal_o   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o      <= ret_any;
      illegal_o   <= ret_bad;
      priv_trap_o <= ret_ok && trap;
      if (ret_ok) begin
        pc_o <= pc_new;
        sr_o <= sr_new;
      end
    end
  end
endmodule

// File: rtl/ret_restore_chk.sv
module ret_restore_chk #(
  parameter int unsigned OPC_W    = 6,
  parameter int unsigned REG_W    = 4,
  parameter logic [OPC_W-1:0] MOVD_OPC = 6'h26,
  parameter int unsigned PC_IDX   = 0,
  parameter int unsigned SR_IDX   = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic [REG_W-1:0] dst_sel_i,
  input logic [REG_W-1:0] src_sel_i,
  input logic [31:0]      pc_word_i,
  input logic [31:0]      sr_word_i,
  input logic [31:0]      cur_sr_i,
  input logic [31:0]      pc_o,
  input logic [31:0]      sr_o,
  input logic             priv_trap_o,
  input logic             illegal_o,
  input logic             done_o
);
  logic is_ret;
  assign is_ret = valid_i && opcode_i == MOVD_OPC && dst_sel_i == REG_W'(PC_IDX);

  // R8
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ret |=> done_o);

  // R1
  no_spur_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ret |=> !done_o && $stable(pc_o) && $stable(sr_o));

  // R2
  pc_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[0] == 1'b0);

  // R3
  ilc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[20:19] == 2'b00);

  // R3
  sup_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o |-> sr_o[18] == $past(pc_word_i[0]));

  // R4
  sup_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ret && src_sel_i > 1 && !cur_sr_i[18] && pc_word_i[0] |=> priv_trap_o);

  // R5
  lock_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ret && src_sel_i > 1 && !pc_word_i[0] && !cur_sr_i[15] && sr_word_i[15] |=> priv_trap_o);

  // R7
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !priv_trap_o && $stable(pc_o) && $stable(sr_o));

  // R4
  trap_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_trap_o |-> done_o);
endmodule

bind ret_restore_unit ret_restore_chk #(
  .OPC_W(OPC_W), .REG_W(REG_W), .MOVD_OPC(MOVD_OPC),
  .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
  .dst_sel_i(dst_sel_i), .src_sel_i(src_sel_i), .pc_word_i(pc_word_i),
  .sr_word_i(sr_word_i), .cur_sr_i(cur_sr_i), .pc_o(pc_o), .sr_o(sr_o),
  .priv_trap_o(priv_trap_o), .illegal_o(illegal_o), .done_o(done_o)
);

// File: tb/sim_ret_restore_unit.sv
module sim_ret_restore_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [3:0]  dst_sel_i = '0;
  logic [3:0]  src_sel_i = '0;
  logic [31:0] pc_word_i = '0;
  logic [31:0] sr_word_i = '0;
  logic [31:0] cur_sr_i = '0;
  logic [31:0] pc_o, sr_o;
  logic        priv_trap_o, illegal_o, done_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] exp_pc = '0;
  logic [31:0] exp_sr = '0;

  always #2.5 clk_i = ~clk_i;

  ret_restore_unit u0 (.*);

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] opc, input logic [3:0] dst, input logic [3:0] src,
                       input logic [31:0] pcw, input logic [31:0] srw, input logic [31:0] cur);
    logic is_ret, rsvd, trap;
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = opc; dst_sel_i = dst; src_sel_i = src;
    pc_word_i = pcw; sr_word_i = srw; cur_sr_i = cur;
    @(negedge clk_i);
    valid_i = 1'b0;
    is_ret = (opc == 6'h26) && (dst == 4'd0);
    rsvd   = is_ret && (src <= 4'd1);
    trap   = is_ret && !rsvd &&
             ((!cur[18] && pcw[0]) || (!pcw[0] && !cur[15] && srw[15]));
    if (is_ret && !rsvd) begin
      exp_pc = {pcw[31:1], 1'b0};
      exp_sr = {srw[31:21], 2'b00, pcw[0], srw[17:0]};
    end
    check("R8 done", 32'(done_o), 32'(is_ret));
    check("R7 illegal", 32'(illegal_o), 32'(rsvd));
    check("R4/R5 trap", 32'(priv_trap_o), 32'(trap));
    check("R2 pc", pc_o, exp_pc);
    check("R3 sr", sr_o, exp_sr);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 pc", pc_o, 0); check("R9 sr", sr_o, 0);
    check("R9 flags", {29'd0, priv_trap_o, illegal_o, done_o}, 0);
    rst_ni = 1'b1;

    // R4 R5 R6: sweep old S, old L, new S, new L
    for (int k = 0; k < 64; k++) begin
      logic [31:0] pcw, srw, cur;
      seed = nxt(seed); pcw = seed; seed = nxt(seed); srw = seed; seed = nxt(seed); cur = seed;
      pcw[0] = k[0]; srw[15] = k[1]; cur[18] = k[2]; cur[15] = k[3];
      issue(6'h26, 4'd0, 4'(2 + k[5:4]), pcw, srw, cur);
    end

    // R1 near-miss opcodes and destinations
    for (int k = 0; k < 16; k++) begin
      seed = nxt(seed);
      issue(6'h26 ^ 6'(1 << (k % 6)), 4'd0, 4'd5, seed, ~seed, 32'd0);
      issue(6'h26, 4'(k == 0 ? 1 : k), 4'd5, seed, ~seed, 32'd0);
    end

    // R7 reserved sources with trap-inducing flags
    for (int k = 0; k < 2; k++) begin
      seed = nxt(seed);
      issue(6'h26, 4'd0, 4'(k), seed | 32'd1, seed | 32'h8000, 32'd0);
    end

    // R9 reset after load
    issue(6'h26, 4'd0, 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R9 pc after load", pc_o, 0); check("R9 sr after load", sr_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule